// File: doc/BRIEF.md
# Memory Bank Lock Controller

This block is the bank-control front end of a memory node. Every command covers one aligned 64-byte cache block. The block sees one command per cycle, picks the target bank from the address, and either admits the command or refuses it. A combinational conflict output is valid in the same cycle as the command, so a commander can cancel a command that would be refused. Each of the sixteen banks has its own busy timer and its own lock flag.

Two special commands give I/O agents atomic access to blocks smaller than a full block. A read-lock reads the block and leaves its bank locked. While the bank is locked, every other access to it is refused. A later write-unlock to the same bank writes the block and releases the lock. A write-unlock that reaches a bank that is not locked is carried out as a plain write and flagged as an error.

Accepted reads return their two 32-byte halves on a one-beat-per-cycle read path in wrapped order. The half named by address bit 5 comes first and the other half follows. DRAM timing, data storage and bus arbitration are handled outside this block.

Top module: `bank_lock_ctrl`

## Requirements
- R1: The bank is address bits 9:6 (16 banks). The busy and lock state of one bank never affects whether a command to another bank is admitted.
- R2: Op codes on `cmd_op_i` are 0 = read, 1 = write, 2 = read-lock and 3 = write-unlock. For each command sampled at a clock edge, exactly one of `resp_ack_o` and `resp_nack_o` is high in the cycle after that edge. Both are low after an edge with no command.
- R3: When a command is accepted at edge n, its bank refuses every command sampled at edges n+1 through n+4 and accepts again at edge n+5. A refused command does not extend the busy period.
- R4: An accepted read-lock locks its bank. While the bank is locked, read, write and read-lock commands to it are refused even after the busy period has ended.
- R5: A write-unlock to a locked bank that is not busy is accepted, clears the lock, and makes the bank busy as in R3. A write-unlock refused because the bank is busy leaves the lock set.
- R6: A write-unlock accepted by a bank that is not locked acts as a write and raises `unlock_err_o` together with its acknowledge. `unlock_err_o` is low in every other cycle.
- R7: For a read or read-lock accepted at edge n, `rd_valid_o` is high in the cycles after edges n and n+1. The first beat carries `rd_sub_o` = address bit 5 and the second carries its inverse, with `rd_last_o` high only on the second. `rd_blk_o` carries address bits 39:6 on both beats.
- R8: A read or read-lock sampled at the edge right after an accepted read or read-lock is refused, whatever its bank. Writes and write-unlocks are not affected by this rule.
- R9: `conflict_o` is high in the cycle a command is presented exactly when that command will be refused at the coming edge. It is low when `cmd_valid_i` is low.
- R10: After reset no bank is busy or locked, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | A command is presented this cycle |
| cmd_op_i | input | 2 | Command op code (R2) |
| cmd_addr_i | input | 35 | Address bits 39:5 of the command |
| conflict_o | output | 1 | Same-cycle prediction that the command will be refused |
| resp_ack_o | output | 1 | Command of the previous edge was accepted |
| resp_nack_o | output | 1 | Command of the previous edge was refused |
| unlock_err_o | output | 1 | Accepted write-unlock found its bank unlocked |
| rd_valid_o | output | 1 | A read subblock beat is present |
| rd_last_o | output | 1 | The beat is the second subblock |
| rd_sub_o | output | 1 | Index of the 32-byte subblock in this beat |
| rd_blk_o | output | 34 | Block address (bits 39:6) of the beat |

## Verification
Two things can meet in one cycle: the second beat of a read that is still in flight, and the admission of a new command. The bench makes them meet by sending a read straight after an accepted read to a different bank, which must be refused, and by sending a write or a read to a free bank in that slot, which must be accepted while the old beat completes untouched. A second meeting point is the edge where a bank's busy period ends. Commands are sent at edges n+4 and n+5, and the refusal must flip to acceptance on exactly the second of these. Every response and beat is compared against a queue of expected items. Each item is stamped with the edge it belongs to and built from a bank model kept in the bench.

// File: rtl/blc_pkg.sv
package blc_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_RDLOCK = 2'd2,
        OP_WRUNLK = 2'd3
    } blc_op_e;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_FIRST  = 2'd1,
        SEQ_SECOND = 2'd2
    } blc_seq_e;

    typedef struct packed {
        logic ack;
        logic nack;
        logic err;
    } blc_resp_s;

endpackage

// File: rtl/blc_bank_slot.sv
module blc_bank_slot #(
    parameter int BUSY_CYC = 4,
    parameter int CNT_W    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic set_lock_i,
    input  logic clr_lock_i,
    output logic busy_o,
    output logic locked_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lock;
    } slot_s;

    slot_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (start_i) begin
            st_d.cnt = CNT_W'(BUSY_CYC);
        end
        if (set_lock_i) begin
            st_d.lock = 1'b1;
        end
        if (clr_lock_i) begin
            st_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = (st_q.cnt != '0);
    assign locked_o = st_q.lock;

endmodule

// File: rtl/blc_wrap_seq.sv
module blc_wrap_seq
    import blc_pkg::*;
#(
    parameter int BLK_W = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             first_sub_i,
    input  logic [BLK_W-1:0] blk_i,
    output logic             beat_valid_o,
    output logic             beat_last_o,
    output logic             beat_sub_o,
    output logic [BLK_W-1:0] beat_blk_o,
    output logic             hold_o
);

    typedef struct packed {
        blc_seq_e         phase;
        logic             sub;
        logic [BLK_W-1:0] blk;
    } seq_s;

    seq_s sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        unique case (sq_q.phase)
            SEQ_FIRST: begin
                sq_d.phase = SEQ_SECOND;
                sq_d.sub   = ~sq_q.sub;
            end
            default: begin
                sq_d.phase = SEQ_IDLE;
            end
        endcase
        if (start_i) begin
            sq_d.phase = SEQ_FIRST;
            sq_d.sub   = first_sub_i;
            sq_d.blk   = blk_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{phase: SEQ_IDLE, sub: 1'b0, blk: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign beat_valid_o = (sq_q.phase != SEQ_IDLE);
    assign beat_last_o  = (sq_q.phase == SEQ_SECOND);
    assign beat_sub_o   = sq_q.sub;
    assign beat_blk_o   = sq_q.blk;
    assign hold_o       = (sq_q.phase == SEQ_FIRST);

endmodule

// File: rtl/blc_admit.sv
module blc_admit
    import blc_pkg::*;
(
    input  logic    cmd_valid_i,
    input  blc_op_e cmd_op_i,
    input  logic    bank_busy_i,
    input  logic    bank_locked_i,
    input  logic    dp_hold_i,
    output logic    conflict_o,
    output logic    accept_o,
    output logic    is_read_o,
    output logic    stray_unlock_o
);

    logic lock_block;
    logic path_block;

    always_comb begin
        is_read_o      = (cmd_op_i == OP_READ) || (cmd_op_i == OP_RDLOCK);
        lock_block     = bank_locked_i && (cmd_op_i != OP_WRUNLK);
        path_block     = is_read_o && dp_hold_i;
        conflict_o     = cmd_valid_i && (bank_busy_i || lock_block || path_block);
        accept_o       = cmd_valid_i && !conflict_o;
        stray_unlock_o = (cmd_op_i == OP_WRUNLK) && !bank_locked_i;
    end

endmodule

// File: rtl/bank_lock_ctrl.sv
module bank_lock_ctrl
    import blc_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int SUB_BIT  = 5,
    parameter int BANK_W   = 4,
    parameter int BUSY_CYC = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid_i,
    input  logic [1:0]                cmd_op_i,
    input  logic [ADDR_W-1:SUB_BIT]   cmd_addr_i,
    output logic                      conflict_o,
    output logic                      resp_ack_o,
    output logic                      resp_nack_o,
    output logic                      unlock_err_o,
    output logic                      rd_valid_o,
    output logic                      rd_last_o,
    output logic                      rd_sub_o,
    output logic [ADDR_W-SUB_BIT-2:0] rd_blk_o
);

    localparam int BLK_LSB = SUB_BIT + 1;
    localparam int BLK_W   = ADDR_W - BLK_LSB;
    localparam int NBANK   = 1 << BANK_W;
    localparam int CNT_W   = $clog2(BUSY_CYC + 1);

    blc_op_e           op;
    logic [BANK_W-1:0] sel_bank;
    logic [NBANK-1:0]  busy_vec;
    logic [NBANK-1:0]  lock_vec;
    logic [NBANK-1:0]  start_vec;
    logic [NBANK-1:0]  set_vec;
    logic [NBANK-1:0]  clr_vec;
    logic              dp_hold;
    logic              accept;
    logic              is_read;
    logic              stray;
    logic              conflict;

    assign op       = blc_op_e'(cmd_op_i);
    assign sel_bank = cmd_addr_i[BLK_LSB +: BANK_W];

    blc_admit u_admit (
        .cmd_valid_i    (cmd_valid_i),
        .cmd_op_i       (op),
        .bank_busy_i    (busy_vec[sel_bank]),
        .bank_locked_i  (lock_vec[sel_bank]),
        .dp_hold_i      (dp_hold),
        .conflict_o     (conflict),
        .accept_o       (accept),
        .is_read_o      (is_read),
        .stray_unlock_o (stray)
    );

    always_comb begin
        start_vec = '0;
        set_vec   = '0;
        clr_vec   = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (accept && (sel_bank == BANK_W'(b))) begin
                start_vec[b] = 1'b1;
                set_vec[b]   = (op == OP_RDLOCK);
                clr_vec[b]   = (op == OP_WRUNLK);
            end
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        blc_bank_slot #(
            .BUSY_CYC (BUSY_CYC),
            .CNT_W    (CNT_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .start_i    (start_vec[g]),
            .set_lock_i (set_vec[g]),
            .clr_lock_i (clr_vec[g]),
            .busy_o     (busy_vec[g]),
            .locked_o   (lock_vec[g])
        );
    end

    blc_wrap_seq #(
        .BLK_W (BLK_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (accept && is_read),
        .first_sub_i  (cmd_addr_i[SUB_BIT]),
        .blk_i        (cmd_addr_i[ADDR_W-1:BLK_LSB]),
        .beat_valid_o (rd_valid_o),
        .beat_last_o  (rd_last_o),
        .beat_sub_o   (rd_sub_o),
        .beat_blk_o   (rd_blk_o),
        .hold_o       (dp_hold)
    );

    blc_resp_s resp_d, resp_q;

    always_comb begin
        resp_d.ack  = accept;
        resp_d.nack = conflict;
        resp_d.err  = accept && stray;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign conflict_o   = conflict;
    assign resp_ack_o   = resp_q.ack;
    assign resp_nack_o  = resp_q.nack;
    assign unlock_err_o = resp_q.err;

endmodule

// File: rtl/blc_checker.sv
module blc_checker #(
    parameter int NBANK  = 16,
    parameter int BANK_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [BANK_W-1:0] sel_bank,
    input logic [NBANK-1:0]  busy_vec,
    input logic [NBANK-1:0]  lock_vec,
    input logic              accept,
    input logic              conflict,
    input logic              ack,
    input logic              nack,
    input logic              err,
    input logic              rd_valid,
    input logic              rd_last,
    input logic              rd_sub
);

    logic rd_cmd;
    assign rd_cmd = (cmd_op == 2'd0) || (cmd_op == 2'd2);

    a_r2_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && nack));

    a_r9_conflict_refused: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && conflict |=> nack);

    a_r3_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && busy_vec[sel_bank] |=> nack);

    a_r4_lock_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && lock_vec[sel_bank] && (cmd_op != 2'd3) |=> nack);

    a_r5_lock_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(lock_vec));

    a_r6_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ack);

    a_r7_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_last |=> rd_valid && rd_last && (rd_sub != $past(rd_sub)));

    a_r8_path_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_last && cmd_valid && rd_cmd |=> nack);

endmodule

bind bank_lock_ctrl blc_checker #(
    .NBANK  (NBANK),
    .BANK_W (BANK_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid_i),
    .cmd_op    (cmd_op_i),
    .sel_bank  (sel_bank),
    .busy_vec  (busy_vec),
    .lock_vec  (lock_vec),
    .accept    (accept),
    .conflict  (conflict_o),
    .ack       (resp_ack_o),
    .nack      (resp_nack_o),
    .err       (unlock_err_o),
    .rd_valid  (rd_valid_o),
    .rd_last   (rd_last_o),
    .rd_sub    (rd_sub_o)
);

// File: tb/bank_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module bank_lock_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [39:5] cmd_addr = '0;
    logic        conflict, ack, nack, uerr, rd_valid, rd_last, rd_sub;
    logic [33:0] rd_blk;

    always #2.5 clk = ~clk;

    bank_lock_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .cmd_addr_i(cmd_addr), .conflict_o(conflict), .resp_ack_o(ack),
        .resp_nack_o(nack), .unlock_err_o(uerr), .rd_valid_o(rd_valid),
        .rd_last_o(rd_last), .rd_sub_o(rd_sub), .rd_blk_o(rd_blk)
    );

    typedef struct { int at; bit a; bit n; bit e; string tag; } resp_t;
    typedef struct { int at; bit sub; bit last; logic [33:0] blk; } beat_t;

    resp_t resp_q[$];
    beat_t beat_q[$];
    int checks = 0;
    int errors = 0;
    int edge_cnt = 0;
    int busy_end[16];
    bit lk[16];
    int last_rd = -10;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h (edge %0d)", tag, what, act, exp, edge_cnt);
        end
    endtask

    function automatic logic [39:5] mk(int bank, int hi, bit b5);
        logic [39:5] a;
        a = '0;
        a[39:10] = 30'(hi);
        a[9:6] = 4'(bank);
        a[5] = b5;
        return a;
    endfunction

    task automatic step(bit v, logic [1:0] op, logic [39:5] a, string tag);
        int k;
        int b;
        bit rd, refuse, acc, err;
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_addr = a;
        #1;
        k = edge_cnt + 1;
        b = int'(a[9:6]);
        rd = (op == 2'd0) || (op == 2'd2);
        refuse = v && ((k <= busy_end[b]) || (lk[b] && op != 2'd3) || (rd && last_rd == k - 1));
        acc = v && !refuse;
        err = acc && (op == 2'd3) && !lk[b];
        chk("R9", "conflict_o", 64'(conflict), 64'(refuse));
        if (acc) begin
            busy_end[b] = k + 4;
            if (op == 2'd2) lk[b] = 1'b1;
            if (op == 2'd3) lk[b] = 1'b0;
            if (rd) begin
                last_rd = k;
                beat_q.push_back('{k, a[5], 1'b0, a[39:6]});
                beat_q.push_back('{k + 1, ~a[5], 1'b1, a[39:6]});
            end
        end
        resp_q.push_back('{k, acc, refuse, err, tag});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0, "R2");
    endtask

    // Monitor: pops expected items stamped with the current edge
    always @(posedge clk) begin
        edge_cnt++;
        #2;
        if (resp_q.size() != 0 && resp_q[0].at == edge_cnt) begin
            resp_t r;
            r = resp_q.pop_front();
            chk(r.tag, "resp_ack_o", 64'(ack), 64'(r.a));
            chk(r.tag, "resp_nack_o", 64'(nack), 64'(r.n));
            chk(r.tag == "R2" ? "R6" : r.tag, "unlock_err_o", 64'(uerr), 64'(r.e));
        end else begin
            chk("R10", "resp idle", 64'({ack, nack, uerr}), 64'd0);
        end
        if (beat_q.size() != 0 && beat_q[0].at == edge_cnt) begin
            beat_t bt;
            bt = beat_q.pop_front();
            chk("R7", "rd_valid_o", 64'(rd_valid), 64'd1);
            chk("R7", "rd_sub_o", 64'(rd_sub), 64'(bt.sub));
            chk("R7", "rd_last_o", 64'(rd_last), 64'(bt.last));
            chk("R7", "rd_blk_o", 64'(rd_blk), 64'(bt.blk));
        end else begin
            chk("R7", "rd_valid_o idle", 64'(rd_valid), 64'd0);
        end
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin busy_end[i] = -1; lk[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);                                        // R10 reset state
        // R1 / R10: writes to all sixteen banks back to back are all accepted
        for (int b = 0; b < 16; b++) step(1'b1, 2'd1, mk(b, b + 7, 1'b0), "R1");
        idle(5);
        // R3: busy window of four edges, refused commands do not extend it
        step(1'b1, 2'd1, mk(3, 1, 1'b0), "R3");
        for (int i = 0; i < 4; i++) step(1'b1, 2'd1, mk(3, 2, 1'b0), "R3");
        step(1'b1, 2'd0, mk(3, 3, 1'b1), "R3");
        idle(5);
        // R7: wrapped subblock order for both values of address bit 5
        step(1'b1, 2'd0, mk(5, 30'h2abcdef1, 1'b1), "R7");
        idle(1);
        step(1'b1, 2'd0, mk(6, 30'h155, 1'b0), "R7");
        idle(2);
        // R8: read right after a read is refused; writes and later reads pass
        step(1'b1, 2'd0, mk(7, 11, 1'b0), "R8");
        step(1'b1, 2'd0, mk(8, 12, 1'b1), "R8");
        step(1'b1, 2'd0, mk(8, 13, 1'b1), "R8");
        step(1'b1, 2'd1, mk(10, 14, 1'b0), "R8");
        step(1'b1, 2'd3, mk(13, 14, 1'b0), "R8");
        idle(5);
        // R4: lock holds past the busy window
        step(1'b1, 2'd2, mk(2, 21, 1'b1), "R4");
        idle(1);
        step(1'b1, 2'd0, mk(3, 22, 1'b0), "R1");         // other bank unaffected
        idle(5);
        step(1'b1, 2'd0, mk(2, 23, 1'b0), "R4");
        step(1'b1, 2'd1, mk(2, 24, 1'b0), "R4");
        step(1'b1, 2'd2, mk(2, 25, 1'b0), "R4");
        // R5: write-unlock releases the lock
        step(1'b1, 2'd3, mk(2, 21, 1'b0), "R5");
        idle(4);
        step(1'b1, 2'd0, mk(2, 26, 1'b0), "R5");
        idle(2);
        // R5: refused write-unlock keeps the lock
        step(1'b1, 2'd2, mk(11, 31, 1'b0), "R5");
        step(1'b1, 2'd3, mk(11, 31, 1'b0), "R5");
        idle(5);
        step(1'b1, 2'd1, mk(11, 32, 1'b0), "R5");
        step(1'b1, 2'd3, mk(11, 31, 1'b0), "R5");
        idle(5);
        step(1'b1, 2'd1, mk(11, 33, 1'b0), "R5");
        idle(5);
        // R6: stray write-unlock acts as a write and flags an error
        step(1'b1, 2'd3, mk(12, 41, 1'b0), "R6");
        step(1'b1, 2'd1, mk(12, 42, 1'b0), "R6");
        idle(4);
        step(1'b1, 2'd0, mk(12, 43, 1'b1), "R6");
        idle(6);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule